// File: doc/BRIEF.md
# Chained-Descriptor Bus-Master DMA Engine

This block moves data for one disk-style device port without processor help. Software sets up three things through a 32-bit word-aligned register port: the address of a descriptor table in memory, the address of a 128-byte completion area, and a control word that holds the direction. It then sets the start bit. The engine reads 16-byte descriptors from the table one after another. Each descriptor names a buffer and a byte length. The engine streams the buffer between memory and the device FIFO one 32-bit word at a time. It keeps separate running byte counts for the device side and the memory side.

The descriptor marked end-of-list ends the transfer. So does a stop request or a memory fault. In each case the engine fills the completion area with all-ones words before it reports idle. Software polls that area in memory. A memory write is therefore known to have landed even on a fabric where a register read can overtake earlier DMA writes. Memory access uses a single-outstanding request/acknowledge port. The device side uses two valid/ready word streams.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset every register reads zero, no memory request is raised and no device word is offered.
- R2: The register port is decoded by word offset: 0 timing, 1 table pointer low, 2 table pointer high, 3 current buffer address, 4 current address high (always zero), 5 device byte count, 6 memory byte count, 7 control/status, 8 completion-area address. Offsets 0, 1, 2 and 8 read back what was written. Writes to offsets 3 to 6 have no effect.
- R3: The control/status word uses bit 0 start, bit 1 stop, bit 2 direction, bit 3 active and bit 4 error. A start is accepted only while active is 0. A start or direction write made while active changes neither the direction nor the byte counts.
- R4: An accepted start clears both byte counts. The engine then reads four words per descriptor at table pointer + 16·n + 0/4/8/12, and byte-swaps each one. Word 1 is the buffer address. Word 3 carries the byte length in bits 15:0 and end-of-list in bit 31.
- R5: With direction 0, buffer words are read from memory at ascending word addresses and offered on the device transmit stream, in order and unchanged.
- R6: With direction 1, words taken from the device receive stream are written to ascending word addresses of the buffer, in order and unchanged.
- R7: A length field of 0 moves 65536 bytes.
- R8: Each word adds 4 to a byte count. A descriptor's final word adds only the bytes that remain. The device count moves at the FIFO handshake and the memory count at the memory acknowledge, and the two never differ by more than 4.
- R9: When the end-of-list descriptor has drained, 32 words of 0xFFFFFFFF are written at ascending addresses from the completion address, and only then does active clear.
- R10: Writing the stop bit halts the engine at the next word boundary and starts the completion write. The stop bit reads 1 until the engine is idle and reads 0 afterwards.
- R11: A memory acknowledge flagged as an error sets the error bit and aborts the transfer through the completion write. The error bit then stays set until a stop is written.
- R12: A memory request holds its address, direction and write data until it is acknowledged. A transmit word holds its data until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_err | input | 1 | Accepted request faulted |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| dev_tx_valid | output | 1 | Word offered to the device |
| dev_tx_ready | input | 1 | Device takes the word |
| dev_tx_data | output | 32 | Word to the device |
| dev_rx_valid | input | 1 | Device offers a word |
| dev_rx_ready | output | 1 | Engine takes the word |
| dev_rx_data | input | 32 | Word from the device |

## Verification
The engine is tried on a two-descriptor memory-to-device chain whose second length is not a multiple of four. This separates correct table walking and partial-word counting from a fixed word count. A single-descriptor device-to-memory run, with a start rewritten mid-transfer, shows that a busy engine ignores a restart that would otherwise reset the counts or flip the direction. A zero-length descriptor exposes a length field read as zero instead of 65536. A stop issued mid-buffer and a faulted read mid-buffer each prove that the engine halts on a word boundary, still writes the completion area, and leaves stop and error in the states software expects. Randomly throttled acknowledges and device readiness separate a design that waits on its handshakes from one that merely happens to match the timing.

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int MARK_BYTES = 128,
  parameter int LEN_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        dev_tx_valid,
  input  logic        dev_tx_ready,
  output logic [31:0] dev_tx_data,
  input  logic        dev_rx_valid,
  output logic        dev_rx_ready,
  input  logic [31:0] dev_rx_data
);
  localparam int MARK_WORDS = MARK_BYTES / 4;
  localparam int MC_W       = $clog2(MARK_WORDS);
  localparam int REM_W      = LEN_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_TX, S_RX, S_WR, S_MARK} st_e;

  st_e              st_q;
  logic [31:0]      timing_q, tbl_lo_q, tbl_hi_q, mark_q;
  logic [31:0]      cur_q, fetch_q, buf_q, bcd_q, bcm_q;
  logic             dir_q, stop_q, err_q, eol_q;
  logic [1:0]       widx_q;
  logic [REM_W-1:0] rem_q;
  logic [MC_W-1:0]  mcnt_q;

  wire        ctrl_wr  = reg_we && reg_addr == 4'd7;
  wire        stop_wr  = ctrl_wr && reg_wdata[1];
  wire        active   = st_q != S_IDLE;
  wire [31:0] step     = (rem_q >= REM_W'(4)) ? 32'd4 : 32'(rem_q[2:0]);
  wire [REM_W-1:0] rem_nx = rem_q - REM_W'(step);
  wire [31:0] rd_sw    = {mem_rdata[7:0], mem_rdata[15:8], mem_rdata[23:16], mem_rdata[31:24]};
  wire [LEN_W-1:0] len_f = rd_sw[LEN_W-1:0];
  st_e        data_st, after_word;
  logic [31:0] addr_c;

  assign data_st    = dir_q ? S_RX : S_RD;
  assign after_word = (rem_nx == '0) ? ((eol_q || stop_q) ? S_MARK : S_FETCH)
                                     : (stop_q ? S_MARK : data_st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      timing_q <= '0; tbl_lo_q <= '0; tbl_hi_q <= '0; mark_q <= '0;
      cur_q <= '0; fetch_q <= '0; buf_q <= '0; bcd_q <= '0; bcm_q <= '0;
      dir_q <= 1'b0; stop_q <= 1'b0; err_q <= 1'b0; eol_q <= 1'b0;
      widx_q <= '0; rem_q <= '0; mcnt_q <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          4'd0: timing_q <= reg_wdata;
          4'd1: tbl_lo_q <= reg_wdata;
          4'd2: tbl_hi_q <= reg_wdata;
          4'd8: mark_q   <= reg_wdata;
          default: ;
        endcase
      end
      if (st_q == S_IDLE) stop_q <= 1'b0;
      if (st_q != S_MARK) mcnt_q <= '0;
      case (st_q)
        S_IDLE: if (ctrl_wr) begin
          dir_q <= reg_wdata[2];
          if (reg_wdata[0]) begin
            fetch_q <= tbl_lo_q;
            widx_q  <= '0;
            bcd_q   <= '0;
            bcm_q   <= '0;
            st_q    <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            st_q  <= S_MARK;
          end else begin
            widx_q <= widx_q + 2'd1;
            if (widx_q == 2'd1) cur_q <= rd_sw;
            if (widx_q == 2'd3) begin
              rem_q   <= (len_f == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len_f};
              eol_q   <= rd_sw[31];
              fetch_q <= fetch_q + 32'd16;
              st_q    <= stop_q ? S_MARK : data_st;
            end
          end
        end
        S_RD: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            st_q  <= S_MARK;
          end else begin
            buf_q <= mem_rdata;
            bcm_q <= bcm_q + step;
            st_q  <= S_TX;
          end
        end
        S_TX: if (dev_tx_ready) begin
          bcd_q <= bcd_q + step;
          rem_q <= rem_nx;
          cur_q <= cur_q + 32'd4;
          st_q  <= after_word;
        end
        S_RX: begin
          if (dev_rx_valid) begin
            buf_q <= dev_rx_data;
            bcd_q <= bcd_q + step;
            st_q  <= S_WR;
          end else if (stop_q) begin
            st_q <= S_MARK;
          end
        end
        S_WR: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            st_q  <= S_MARK;
          end else begin
            bcm_q <= bcm_q + step;
            rem_q <= rem_nx;
            cur_q <= cur_q + 32'd4;
            st_q  <= after_word;
          end
        end
        S_MARK: if (mem_ack) begin
          mcnt_q <= mcnt_q + 1'b1;
          if (mcnt_q == MC_W'(MARK_WORDS - 1)) begin
            st_q   <= S_IDLE;
            stop_q <= 1'b0;
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if (stop_wr) begin
        stop_q <= 1'b1;
        err_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    case (st_q)
      S_FETCH: addr_c = fetch_q + {28'd0, widx_q, 2'b00};
      S_MARK:  addr_c = mark_q + (32'(mcnt_q) << 2);
      default: addr_c = cur_q;
    endcase
  end

  assign mem_req      = st_q == S_FETCH || st_q == S_RD || st_q == S_WR || st_q == S_MARK;
  assign mem_we       = st_q == S_WR || st_q == S_MARK;
  assign mem_addr     = {addr_c[31:2], 2'b00};
  assign mem_wdata    = (st_q == S_MARK) ? 32'hFFFF_FFFF : buf_q;
  assign dev_tx_valid = st_q == S_TX;
  assign dev_tx_data  = buf_q;
  assign dev_rx_ready = st_q == S_RX;

  always_comb begin
    case (reg_addr)
      4'd0: reg_rdata = timing_q;
      4'd1: reg_rdata = tbl_lo_q;
      4'd2: reg_rdata = tbl_hi_q;
      4'd3: reg_rdata = cur_q;
      4'd5: reg_rdata = bcd_q;
      4'd6: reg_rdata = bcm_q;
      4'd7: reg_rdata = {27'd0, err_q, active, dir_q, stop_q, 1'b0};
      4'd8: reg_rdata = mark_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid && !dev_tx_ready |=> dev_tx_valid && $stable(dev_tx_data)); // R12
  AST_SKEW_TO_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    active && !dir_q |-> (bcm_q - bcd_q) <= 32'd4); // R8
  AST_SKEW_TO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    active && dir_q |-> (bcd_q - bcm_q) <= 32'd4); // R8
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(ctrl_wr && reg_wdata[0])); // R3
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !stop_wr |=> !stop_q); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !stop_wr |=> err_q); // R11
  AST_END_AFTER_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(mem_ack && mem_we)); // R9
endmodule

// File: tb/dma_chain_engine_tb_top.sv
module dma_chain_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic dev_tx_valid, dev_rx_ready;
  logic dev_tx_ready = 1'b0, dev_rx_valid = 1'b0;
  logic [31:0] dev_tx_data, dev_rx_data = '0;

  always #4 clk = ~clk;

  dma_chain_engine dut_i (.*);

  localparam logic [31:0] MARK = 32'h0000_8000;
  int total = 0, bad = 0, cyc = 0, tx_seen = 0;
  logic [31:0] q_rd[$];
  logic [31:0] q_tx[$];
  logic [63:0] q_wr[$];
  logic [31:0] mem_m [logic [31:0]];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] rx_word = 32'hC0DE_0001;
  logic [15:0] lfsr = 16'hACE1;
  logic rx_en = 1'b0, fast = 1'b0;
  logic prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;

  function automatic logic [31:0] pat(logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'h5A5A_C3C3;
  endfunction
  function automatic logic [31:0] bsw(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ack = 1'b0;
    mem_err = 1'b0;
    if (rst_n) begin
      if (prev_wait) check(mem_req && mem_addr == prev_addr, "R12 held request", mem_addr, prev_addr);
      if (mem_req && (fast || lfsr[1:0] != 2'b00)) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          if (q_wr.size() == 0) check(0, "R6 unexpected write", mem_addr, 0);
          else begin
            logic [63:0] e;
            e = q_wr.pop_front();
            check({mem_addr, mem_wdata} == e,
                  (mem_addr >= MARK && mem_addr < MARK + 128) ? "R9 marker write" : "R6 data write",
                  mem_wdata, e[31:0]);
          end
          mem_m[mem_addr] = mem_wdata;
        end else begin
          if (q_rd.size() == 0) check(0, "R4 unexpected read", mem_addr, 0);
          else begin
            logic [31:0] e;
            e = q_rd.pop_front();
            check(mem_addr == e, "R4 read address", mem_addr, e);
          end
          mem_rdata = mem_m.exists(mem_addr) ? mem_m[mem_addr] : pat(mem_addr);
          if (mem_addr == err_addr) mem_err = 1'b1;
        end
      end
      prev_wait = mem_req && !mem_ack;
      prev_addr = mem_addr;
      dev_tx_ready = fast || lfsr[2];
      if (dev_tx_valid && dev_tx_ready) begin
        tx_seen++;
        if (q_tx.size() == 0) check(0, "R5 unexpected tx word", dev_tx_data, 0);
        else begin
          logic [31:0] e;
          e = q_tx.pop_front();
          check(dev_tx_data == e, "R5 tx word", dev_tx_data, e);
        end
      end
      dev_rx_valid = rx_en && (fast || lfsr[3]);
      dev_rx_data = rx_word;
      if (dev_rx_valid && dev_rx_ready) rx_word = rx_word + 1;
    end
  end

  task automatic reg_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask
  task automatic reg_rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask
  task automatic wait_idle(int limit);
    logic [31:0] s;
    int n = 0;
    do begin
      reg_rd(4'd7, s);
      n++;
    end while (s[3] && n < limit);
    check(!s[3], "R9 active clears", s, 0);
  endtask
  task automatic put_desc(logic [31:0] tbl, int idx, logic [31:0] a, logic [15:0] len, bit eol);
    logic [31:0] b;
    b = tbl + 32'(idx) * 16;
    mem_m[b] = 0;
    mem_m[b + 4] = bsw(a);
    mem_m[b + 8] = 0;
    mem_m[b + 12] = bsw({eol, 15'd0, len});
    for (int k = 0; k < 4; k++) q_rd.push_back(b + 32'(k) * 4);
  endtask
  task automatic exp_to_dev(logic [31:0] a, int nbytes);
    for (int k = 0; k < (nbytes + 3) / 4; k++) begin
      q_rd.push_back(a + 32'(k) * 4);
      q_tx.push_back(pat(a + 32'(k) * 4));
    end
  endtask
  task automatic exp_marker();
    for (int k = 0; k < 32; k++) q_wr.push_back({MARK + 32'(k) * 4, 32'hFFFF_FFFF});
  endtask
  task automatic check_counts(logic [31:0] d, logic [31:0] m, string req);
    logic [31:0] v;
    reg_rd(4'd5, v); check(v == d, req, v, d);
    reg_rd(4'd6, v); check(v == m, req, v, m);
  endtask
  task automatic check_drained(string req);
    check(q_rd.size() == 0 && q_tx.size() == 0 && q_wr.size() == 0, req,
          q_rd.size() + q_tx.size() + q_wr.size(), 0);
  endtask

  initial begin
    logic [31:0] v, s;
    int words;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a <= 8; a++) begin
      reg_rd(4'(a), v);
      check(v == 0, "R1 reset register", v, 0);
    end
    check(!mem_req && !dev_tx_valid, "R1 idle outputs", {30'd0, mem_req, dev_tx_valid}, 0);

    // R2 register map
    reg_wr(4'd0, 32'h1234_5678);
    reg_wr(4'd2, 32'h0000_ABCD);
    reg_wr(4'd1, 32'h0000_1000);
    reg_wr(4'd8, MARK);
    reg_wr(4'd5, 32'hFFFF);
    reg_wr(4'd3, 32'h7777);
    reg_rd(4'd0, v); check(v == 32'h1234_5678, "R2 timing readback", v, 32'h1234_5678);
    reg_rd(4'd2, v); check(v == 32'h0000_ABCD, "R2 table high readback", v, 32'h0000_ABCD);
    reg_rd(4'd1, v); check(v == 32'h1000, "R2 table low readback", v, 32'h1000);
    reg_rd(4'd8, v); check(v == MARK, "R2 marker readback", v, MARK);
    reg_rd(4'd5, v); check(v == 0, "R2 count ignores write", v, 0);
    reg_rd(4'd3, v); check(v == 0, "R2 address ignores write", v, 0);

    // R4 R5 R8 R9: two descriptors to device, second ends mid-word
    put_desc(32'h1000, 0, 32'h0002_0000, 16'd12, 1'b0);
    exp_to_dev(32'h0002_0000, 12);
    put_desc(32'h1000, 1, 32'h0003_0100, 16'd6, 1'b1);
    exp_to_dev(32'h0003_0100, 6);
    exp_marker();
    reg_wr(4'd7, 32'h1);
    wait_idle(2000);
    check_counts(32'd18, 32'd18, "R8 partial word counts");
    check_drained("R4 chain fully consumed");
    reg_rd(4'd3, v); check(v == 32'h0003_0108, "R2 current address", v, 32'h0003_0108);

    // R6 R3: device to memory, restart attempt while busy
    reg_wr(4'd1, 32'h0000_1100);
    put_desc(32'h1100, 0, 32'h0006_0000, 16'd8, 1'b1);
    q_wr.push_back({32'h0006_0000, 32'hC0DE_0001});
    q_wr.push_back({32'h0006_0004, 32'hC0DE_0002});
    exp_marker();
    reg_wr(4'd7, 32'h5);
    repeat (30) @(negedge clk);
    check_counts(32'd0, 32'd0, "R4 counts cleared by start");
    reg_wr(4'd7, 32'h1);
    reg_rd(4'd7, s);
    check(s[3] && s[2], "R3 busy start ignored", s, 32'hC);
    rx_en = 1'b1;
    wait_idle(2000);
    rx_en = 1'b0;
    check_counts(32'd8, 32'd8, "R6 device to memory counts");
    check_drained("R6 writes complete");
    check(mem_m[32'h0006_0004] == 32'hC0DE_0002, "R6 stored word", mem_m[32'h0006_0004], 32'hC0DE_0002);

    // R7: zero length means 65536 bytes
    fast = 1'b1;
    reg_wr(4'd1, 32'h0000_1200);
    put_desc(32'h1200, 0, 32'h0007_0000, 16'd0, 1'b1);
    exp_to_dev(32'h0007_0000, 65536);
    exp_marker();
    reg_wr(4'd7, 32'h1);
    wait_idle(100000);
    fast = 1'b0;
    check_counts(32'h10000, 32'h10000, "R7 zero length counts");
    check_drained("R7 all words moved");

    // R10: stop in mid buffer
    reg_wr(4'd1, 32'h0000_1300);
    put_desc(32'h1300, 0, 32'h0004_0000, 16'h100, 1'b1);
    exp_to_dev(32'h0004_0000, 256);
    exp_marker();
    tx_seen = 0;
    reg_wr(4'd7, 32'h1);
    while (tx_seen < 5) @(negedge clk);
    reg_wr(4'd7, 32'h2);
    reg_rd(4'd7, s);
    check(s[1] == 1'b1, "R10 stop reads one while busy", s, 32'h2);
    wait_idle(2000);
    reg_rd(4'd7, s);
    check(s[1] == 1'b0, "R10 stop clears when idle", s, 0);
    reg_rd(4'd5, v);
    check(v[1:0] == 0 && v < 256 && v >= 20, "R10 halted on word boundary", v, 20);
    words = 64 - int'(v / 4);
    check(q_tx.size() == words && q_rd.size() == words, "R10 no words after stop", q_tx.size(), words);
    check(q_wr.size() == 0, "R10 marker written", q_wr.size(), 0);
    q_rd.delete(); q_tx.delete();

    // R11: memory fault on third data word
    reg_wr(4'd1, 32'h0000_1400);
    put_desc(32'h1400, 0, 32'h0005_0000, 16'd16, 1'b1);
    exp_to_dev(32'h0005_0000, 16);
    exp_marker();
    err_addr = 32'h0005_0008;
    reg_wr(4'd7, 32'h1);
    wait_idle(2000);
    err_addr = 32'hFFFF_FFFF;
    reg_rd(4'd7, s);
    check(s[4] == 1'b1, "R11 error set", s, 32'h10);
    check_counts(32'd8, 32'd8, "R11 counts at fault");
    check(q_tx.size() == 2 && q_rd.size() == 1 && q_wr.size() == 0, "R11 aborted through marker",
          q_tx.size(), 2);
    q_rd.delete(); q_tx.delete();
    reg_wr(4'd0, 32'h0);
    reg_rd(4'd7, s);
    check(s[4] == 1'b1, "R11 error survives other writes", s, 32'h10);
    reg_wr(4'd7, 32'h2);
    reg_rd(4'd7, s);
    check(s[4] == 1'b0 && s[1] == 1'b0, "R11 stop clears error", s, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule